// File: doc/BRIEF.md
# Byte-Serial CRC-8 Frame Generator and Checker

This block computes the 8-bit check byte that closes a short serial datagram, and it can also confirm that byte on a frame that has been received. Bytes arrive one per cycle on a valid/ready stream. The design never pushes back, so each byte is folded into the running remainder in the cycle it arrives. A flag on the final byte of a frame marks the end of the frame. One cycle after that byte, the block raises a one-cycle done pulse. The result and the match flag stay registered on the outputs until the next frame completes.

The remainder uses the generator x^8+x^2+x+1 and starts from zero for every frame. Each byte is consumed starting at its least significant bit, and the register itself shifts toward its most significant bit. The output has no reflection and no final inversion. A typical request of three header bytes, or seven bytes when it carries a 32-bit payload, is sent in generate mode, and the result becomes the byte that follows. A reply is sent in check mode with its trailing check byte included. The block then compares that final byte against the remainder of everything before it.

Top module: `crc8_frame_engine`

## Requirements
- R1: During and after reset, `done`, `crc_out` and `crc_ok` are 0. `s_ready` is 1 whenever `rst` is low.
- R2: Each byte updates the remainder one bit at a time, bit 0 first. At each bit, if remainder bit 7 XOR the data bit is 1, the remainder becomes (remainder<<1)^0x07; otherwise it becomes remainder<<1. The remainder starts at 0x00 and has no final XOR, so the single-byte frame 0x01 yields 0x89.
- R3: In generate mode (`s_check`=0 with the last byte), `done` pulses in the cycle after the last byte is accepted. `crc_out` is then the remainder over every byte of the frame, including the last, and `crc_ok` is 0.
- R4: In check mode (`s_check`=1 with the last byte), `crc_out` is the remainder over all bytes before the last. `crc_ok` is 1 exactly when the last byte equals that value. The results appear with the `done` pulse.
- R5: After a last byte is accepted, the next frame starts from 0x00 with no clear needed. Frames may follow each other with no idle cycle, and then `done` pulses on consecutive cycles.
- R6: A `clear` pulse throws away any partial frame. A byte accepted in the same cycle as `clear` is treated as the first byte of a new frame.
- R7: Cycles with `s_valid` low change nothing. Between `done` pulses, `crc_out` and `crc_ok` hold their values.
- R8: A check-mode frame of a single byte is compared against 0x00, the remainder of an empty prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Start-of-frame clear of the running remainder |
| s_valid | input | 1 | Byte present on `s_data` |
| s_ready | output | 1 | Byte accepted (always high out of reset) |
| s_data | input | 8 | Data byte |
| s_last | input | 1 | This byte ends the frame |
| s_check | input | 1 | With `s_last`: 1 = verify last byte, 0 = generate |
| done | output | 1 | One-cycle pulse after a frame ends |
| crc_out | output | 8 | Result remainder, held until the next `done` |
| crc_ok | output | 1 | Check-mode match flag, held until the next `done` |

## Verification
The assertions assume that `s_valid`, `s_last`, `s_check` and `clear` are driven to known levels from reset onward. They are driven low while `rst` is high, because several properties look one cycle into the past right after reset. The assertions also assume that `s_last` and `s_check` only matter when `s_valid` is high. The bench changes inputs only on falling edges and holds every control low during reset. The frames it sends include idle gaps between bytes, back-to-back endings, clears with and without a byte in the same cycle, and check frames whose trailing byte is either correct or corrupted.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int CRC_W  = 8;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        MODE_GENERATE = 1'b0,
        MODE_VERIFY   = 1'b1
    } frame_mode_e;

    typedef struct packed {
        crc_t value;
        logic match;
    } frame_result_t;

    // One shift of the remainder register with one incoming data bit.
    function automatic crc_t crc_bit_step(input crc_t rem, input logic din, input crc_t poly);
        crc_t shifted;
        shifted = {rem[CRC_W-2:0], 1'b0};
        return (rem[CRC_W-1] ^ din) ? (shifted ^ poly) : shifted;
    endfunction

endpackage

// File: rtl/crc8_byte_step.sv
module crc8_byte_step
    import crc8_pkg::*;
#(
    parameter crc_t POLY      = 8'h07,
    parameter bit   LSB_FIRST = 1'b1
) (
    input  crc_t  rem_in,
    input  byte_t data_in,
    output crc_t  rem_out
);
    localparam int NBITS = BYTE_W;

    byte_t ordered;

    generate
        if (LSB_FIRST) begin : g_lsb_first
            assign ordered = data_in;
        end else begin : g_msb_first
            for (genvar k = 0; k < NBITS; k++) begin : g_rev
                assign ordered[k] = data_in[NBITS-1-k];
            end
        end
    endgenerate

    // Eight serial bit steps unrolled into one combinational stage.
    always_comb begin
        crc_t acc;
        acc = rem_in;
        for (int i = 0; i < NBITS; i++) begin
            acc = crc_bit_step(acc, ordered[i], POLY);
        end
        rem_out = acc;
    end

endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
    import crc8_pkg::*;
#(
    parameter crc_t POLY = 8'h07,
    parameter crc_t INIT = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  in_valid,
    input  byte_t in_data,
    input  logic  in_last,
    output crc_t  rem_prior,
    output crc_t  rem_incl
);
    crc_t rem_q;

    // A clear in the same cycle as a byte restarts the frame under that byte.
    assign rem_prior = clear ? INIT : rem_q;

    crc8_byte_step #(
        .POLY      (POLY),
        .LSB_FIRST (1'b1)
    ) u_step (
        .rem_in  (rem_prior),
        .data_in (in_data),
        .rem_out (rem_incl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= INIT;
        end else if (in_valid && in_last) begin
            rem_q <= INIT;
        end else if (in_valid) begin
            rem_q <= rem_incl;
        end else if (clear) begin
            rem_q <= INIT;
        end
    end

    // R5: a completed frame leaves the register at its start value
    p_restart_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_last) |-> (rem_q == INIT));

    // R6: a lone clear empties the register
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (rst)
        $past(clear && !in_valid) |-> (rem_q == INIT));

    // R7: idle cycles leave the register untouched
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!in_valid && !clear) |-> $stable(rem_q));

endmodule

// File: rtl/crc8_result.sv
module crc8_result
    import crc8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  verify,
    input  byte_t last_byte,
    input  crc_t  rem_prior,
    input  crc_t  rem_incl,
    output logic  done,
    output crc_t  crc_value,
    output logic  crc_match
);
    frame_mode_e   mode;
    frame_result_t res_d, res_q;
    logic          done_q;

    assign mode = verify ? MODE_VERIFY : MODE_GENERATE;

    always_comb begin
        unique case (mode)
            MODE_VERIFY: begin
                res_d.value = rem_prior;
                res_d.match = (last_byte == rem_prior);
            end
            default: begin
                res_d.value = rem_incl;
                res_d.match = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire;
            if (fire) begin
                res_q <= res_d;
            end
        end
    end

    assign done      = done_q;
    assign crc_value = res_q.value;
    assign crc_match = res_q.match;

    // R3: done follows a last-byte acceptance by one cycle
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fire));

    // R7: results hold between done pulses
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(crc_value) && $stable(crc_match)));

    // R4: a match can only appear with a completed frame
    p_match_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_match) |-> done);

endmodule

// File: rtl/crc8_frame_engine.sv
module crc8_frame_engine
    import crc8_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic [7:0] s_data,
    input  logic       s_last,
    input  logic       s_check,
    output logic       done,
    output logic [7:0] crc_out,
    output logic       crc_ok
);
    crc_t rem_prior;
    crc_t rem_incl;
    logic accept;

    assign s_ready = !rst;
    assign accept  = s_valid && s_ready;

    crc8_accum #(
        .POLY (POLY),
        .INIT (INIT)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .in_valid  (accept),
        .in_data   (s_data),
        .in_last   (s_last),
        .rem_prior (rem_prior),
        .rem_incl  (rem_incl)
    );

    crc8_result u_result (
        .clk       (clk),
        .rst       (rst),
        .fire      (accept && s_last),
        .verify    (s_check),
        .last_byte (s_data),
        .rem_prior (rem_prior),
        .rem_incl  (rem_incl),
        .done      (done),
        .crc_value (crc_out),
        .crc_match (crc_ok)
    );

    // R1: outputs are cleared one edge into reset
    p_reset_clean_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done && !crc_ok && (crc_out == 8'h00)));

endmodule

// File: tb/crc8_frame_engine_tb.sv
module crc8_frame_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       s_check = 1'b0;
    logic       done;
    logic [7:0] crc_out;
    logic       crc_ok;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [7:0] crc;
        logic       ok;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    crc8_frame_engine u_dut (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .s_last  (s_last),
        .s_check (s_check),
        .done    (done),
        .crc_out (crc_out),
        .crc_ok  (crc_ok)
    );

    // Model of the bit rule from R2, written from the requirement text.
    function automatic logic [7:0] model_crc(input logic [7:0] bytes[$], input int count);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < count; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (r[7] ^ bytes[i][b]) r = {r[6:0], 1'b0} ^ 8'h07;
                else                    r = {r[6:0], 1'b0};
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
            s_check = 1'b0;
            clear   = 1'b0;
        end
    endtask

    // Driver: sends one frame and pushes the expected result.
    task automatic send_frame(input logic [7:0] bytes[$], input bit chk, input int gap,
                              input bit clr_first, input string tag);
        exp_t e;
        int n;
        n = bytes.size();
        if (chk) begin
            e.crc = model_crc(bytes, n - 1);
            e.ok  = (bytes[n-1] == e.crc);
        end else begin
            e.crc = model_crc(bytes, n);
            e.ok  = 1'b0;
        end
        e.tag = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = bytes[i];
            s_last  = (i == n - 1);
            s_check = chk;
            clear   = clr_first && (i == 0);
            if (i == n - 1) sb_q.push_back(e);
            if (gap > 0 && i != n - 1) idle(gap);
        end
    endtask

    // Monitor: compares every done pulse with the scoreboard head.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R3: actual done=1 expected no pending frame");
            end else begin
                e = sb_q.pop_front();
                check({e.tag, " crc"}, {24'h0, crc_out}, {24'h0, e.crc});
                check({e.tag, " ok"}, {31'h0, crc_ok}, {31'h0, e.ok});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] f[$];
        logic [7:0] held_crc;
        logic       held_ok;

        repeat (4) @(posedge clk);
        #2;
        // R1: reset state
        check("R1 done in reset", {31'h0, done}, 32'h0);
        check("R1 crc in reset", {24'h0, crc_out}, 32'h0);
        check("R1 ok in reset", {31'h0, crc_ok}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 ready", {31'h0, s_ready}, 32'h1);

        // R2: fixed anchor value for a single byte 0x01
        f = '{8'h01};
        send_frame(f, 1'b0, 0, 1'b0, "R2 byte01");
        idle(1);
        @(posedge clk);
        #2;
        check("R2 literal 0x89", {24'h0, crc_out}, 32'h89);

        f = '{8'h80}; send_frame(f, 1'b0, 0, 1'b0, "R2 byte80"); idle(1);
        f = '{8'hFF}; send_frame(f, 1'b0, 0, 1'b0, "R2 byteFF"); idle(1);

        // R3: three-byte and seven-byte requests
        f = '{8'hA0, 8'h00, 8'h0C};
        send_frame(f, 1'b0, 0, 1'b0, "R3 read3"); idle(2);
        f = '{8'hA0, 8'h03, 8'hE1, 8'h12, 8'h34, 8'h56, 8'h78};
        send_frame(f, 1'b0, 0, 1'b0, "R3 write7"); idle(2);

        // R4: valid reply and corrupted reply
        f = '{8'h05, 8'hFF, 8'h22, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
        f.push_back(model_crc(f, 7));
        send_frame(f, 1'b1, 0, 1'b0, "R4 good"); idle(1);
        f[7] = f[7] ^ 8'h10;
        send_frame(f, 1'b1, 0, 1'b0, "R4 bad"); idle(1);

        // R8: single-byte check frames against 0x00
        f = '{8'h00}; send_frame(f, 1'b1, 0, 1'b0, "R8 zero"); idle(1);
        f = '{8'h07}; send_frame(f, 1'b1, 0, 1'b0, "R8 nonzero"); idle(1);

        // R5: back-to-back frames without clear
        f = '{8'h11, 8'h22, 8'h33};
        send_frame(f, 1'b0, 0, 1'b0, "R5 first");
        f = '{8'h44, 8'h55};
        send_frame(f, 1'b0, 0, 1'b0, "R5 second");
        f = '{8'h66};
        send_frame(f, 1'b0, 0, 1'b0, "R5 third");
        idle(2);

        // R6: partial frame then lone clear
        @(negedge clk); s_valid = 1'b1; s_data = 8'h9A; s_last = 1'b0;
        @(negedge clk); s_data = 8'h3C;
        @(negedge clk); s_valid = 1'b0; clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        f = '{8'hA0, 8'h01, 8'h04};
        send_frame(f, 1'b0, 0, 1'b0, "R6 lone clear"); idle(1);

        // R6: partial frame then clear with first byte
        @(negedge clk); s_valid = 1'b1; s_data = 8'h5A; s_last = 1'b0;
        f = '{8'hA0, 8'h02, 8'h08};
        send_frame(f, 1'b0, 0, 1'b1, "R6 clear with byte"); idle(1);

        // R7: gaps between bytes
        f = '{8'hA0, 8'h01, 8'h0D, 8'h00, 8'h00, 8'h01, 8'hF4};
        send_frame(f, 1'b0, 3, 1'b0, "R7 gapped");
        f = '{8'hA0, 8'h02, 8'h42};
        f.push_back(model_crc(f, 3));
        send_frame(f, 1'b1, 2, 1'b0, "R7 gapped check");
        idle(2);

        // R7: outputs hold over idle cycles and over an unfinished frame
        held_crc = model_crc(f, 3);
        held_ok  = 1'b1;
        @(negedge clk); s_valid = 1'b1; s_data = 8'h77; s_last = 1'b0;
        idle(5);
        @(posedge clk);
        #2;
        check("R7 crc held", {24'h0, crc_out}, {24'h0, held_crc});
        check("R7 ok held", {31'h0, crc_ok}, {31'h0, held_ok});
        check("R7 no done", {31'h0, done}, 32'h0);

        idle(3);
        check("R3 scoreboard drained", sb_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule